// File: doc/BRIEF.md
# Supply Reset Supervisor with Watchdog Ramp

This block holds a system in reset until its supply is good and has stayed good for a programmable settling time. It then releases an active-low reset and starts a watchdog. The analog capacitor timing is replaced by two digital counters. A delay counter sets the power-up release time. An up/down ramp counter stands in for the watchdog capacitor: it climbs in a charge phase and falls in a discharge phase.

While the ramp is falling, software must pulse the kick input, and the ramp then climbs back to the top. If the ramp reaches zero first, the block drives reset low for a pulse. The length of that pulse is the time the ramp takes to climb from zero to the top again. Because the climb step is a fixed multiple of the fall step, the pulse is a fixed fraction of the timeout.

A low supply flag always forces reset and restarts the whole release sequence. A low watchdog enable freezes only the ramp, so supply supervision continues while the watchdog is off.

Top module: `rst_wdog_sup`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `reset_n` is 0, `sup_state` is 0 (hold) and `wd_charging` is 1.
- R2: When `supply_ok` is high in hold, the next edge enters delay (`sup_state` 1). After exactly `cfg_delay` edges in delay, `reset_n` goes to 1 and `sup_state` goes to 2 (run).
- R3: On release, the ramp starts at 0 in the charge phase (`wd_charging` 1) and rises by CHG_STEP per cycle. On the edge where the rise would reach `cfg_timeout`, it sets the level to `cfg_timeout` and enters the discharge phase (`wd_charging` 0). The level never exceeds `cfg_timeout`.
- R4: In the discharge phase the level falls by 1 per cycle. On the edge after it sits at 0 with no kick, `reset_n` goes to 0 and `sup_state` goes to 3 (watchdog reset). With no kicks this happens ceil(`cfg_timeout`/CHG_STEP) + `cfg_timeout` + 1 cycles after release.
- R5: A watchdog reset puts the ramp in the charge phase from 0. `reset_n` stays 0 for ceil(`cfg_timeout`/CHG_STEP) cycles, and then returns to 1 in run with the ramp discharging.
- R6: A rising edge on `kick` acts three edges after it is set up (two synchronizer flops plus an edge flop). If the ramp is discharging at that point, the ramp switches to charging and keeps its current level for that cycle.
- R7: A kick edge that arrives while the ramp is charging has no effect on the reset timing. A kick held high counts as a single edge.
- R8: `supply_ok` low at any edge, in any state and with the watchdog on or off, gives hold and `reset_n` 0 after that edge.
- R9: After a supply failure, including one during the delay, `reset_n` rises only after a complete new count of `cfg_delay` edges in delay.
- R10: While `wd_enable` is low, the ramp level is frozen, the phase is set to charging and no watchdog reset occurs. When it returns high, the ramp charges upward from the frozen level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply-good flag from the external comparators, synchronous to clk |
| kick | input | 1 | Watchdog service input, may be asynchronous |
| wd_enable | input | 1 | Watchdog enable; low freezes the ramp |
| cfg_delay | input | DLY_W | Release delay in cycles |
| cfg_timeout | input | TMO_W | Ramp upper limit, which is the discharge time in cycles |
| reset_n | output | 1 | Active-low system reset, registered |
| sup_state | output | 2 | Supervisor state: 0 hold, 1 delay, 2 run, 3 watchdog reset |
| wd_charging | output | 1 | 1 while the ramp is in its charge phase |

## Verification
The assertions assume that `supply_ok` and `wd_enable` are already synchronous to the clock and that `cfg_timeout` and `cfg_delay` stay constant whenever the block is outside hold. The level-cap property would fire if the upper limit were lowered under a high ramp. The bench writes the configuration words once, before it releases reset. It changes `supply_ok` and `wd_enable` only on falling clock edges. Only `kick` is treated as asynchronous, and the bench holds it high for several cycles so that the single-edge rule is exercised.

// File: rtl/rst_wdog_pkg.sv
package rst_wdog_pkg;

    typedef enum logic [1:0] {
        SUP_HOLD  = 2'd0,
        SUP_DELAY = 2'd1,
        SUP_RUN   = 2'd2,
        SUP_WDRST = 2'd3
    } sup_state_e;

    typedef struct packed {
        logic at_top;    // charge step reaches upper limit this cycle
        logic expired;   // discharging, at zero, no kick
        logic charging;  // current phase
    } ramp_flags_t;

    function automatic logic ramp_active(input sup_state_e s);
        return (s == SUP_RUN) || (s == SUP_WDRST);
    endfunction

endpackage

// File: rtl/rwd_kick_sync.sv
module rwd_kick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic kick_raw,
    output logic kick_rise
);
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= {pipe_q[STAGES-1:0], kick_raw};
    end

    assign kick_rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];

    // R7
    single_kick_chk: assert property (@(posedge clk) disable iff (rst)
        kick_rise |=> !kick_rise);
endmodule

// File: rtl/rwd_delay.sv
module rwd_delay #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             counting,
    input  logic [DLY_W-1:0] cfg_delay,
    output logic             done
);
    logic [DLY_W-1:0] cnt_q;
    logic [DLY_W:0]   cnt_nxt;

    assign cnt_nxt = {1'b0, cnt_q} + (DLY_W+1)'(1);
    assign done    = counting && (cnt_nxt >= {1'b0, cfg_delay});

    always_ff @(posedge clk) begin
        if (rst || !counting) cnt_q <= '0;
        else if (!done)       cnt_q <= cnt_nxt[DLY_W-1:0];
    end

    // R9
    restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !counting |=> (cnt_q == '0));
endmodule

// File: rtl/rwd_ramp.sv
module rwd_ramp
    import rst_wdog_pkg::*;
#(
    parameter int TMO_W    = 16,
    parameter int CHG_STEP = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             enable,
    input  logic             kick_rise,
    input  logic [TMO_W-1:0] cfg_timeout,
    output ramp_flags_t      flags
);
    localparam logic [TMO_W:0] STEP_EXT = (TMO_W+1)'(CHG_STEP);

    logic [TMO_W-1:0] level_q;
    logic             charging_q;
    logic [TMO_W:0]   rise_sum;
    logic             live;

    assign rise_sum       = {1'b0, level_q} + STEP_EXT;
    assign live           = active && enable;
    assign flags.at_top   = live && charging_q && (rise_sum >= {1'b0, cfg_timeout});
    assign flags.expired  = live && !charging_q && !kick_rise && (level_q == '0);
    assign flags.charging = charging_q;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            level_q    <= '0;
            charging_q <= 1'b1;
        end else if (!enable) begin
            charging_q <= 1'b1;
        end else if (charging_q) begin
            if (flags.at_top) begin
                level_q    <= cfg_timeout;
                charging_q <= 1'b0;
            end else begin
                level_q    <= rise_sum[TMO_W-1:0];
            end
        end else if (kick_rise || (level_q == '0)) begin
            charging_q <= 1'b1;
        end else begin
            level_q    <= level_q - 1'b1;
        end
    end

    // R3
    level_cap_chk: assert property (@(posedge clk) disable iff (rst)
        level_q <= cfg_timeout);
    // R10
    frozen_level_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !enable) |=> $stable(level_q));
    // R6
    kick_recharge_chk: assert property (@(posedge clk) disable iff (rst)
        (active && enable && !charging_q && kick_rise) |=> (charging_q && $stable(level_q)));
endmodule

// File: rtl/rst_wdog_sup.sv
module rst_wdog_sup
    import rst_wdog_pkg::*;
#(
    parameter int DLY_W       = 16,
    parameter int TMO_W       = 16,
    parameter int CHG_STEP    = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             supply_ok,
    input  logic             kick,
    input  logic             wd_enable,
    input  logic [DLY_W-1:0] cfg_delay,
    input  logic [TMO_W-1:0] cfg_timeout,
    output logic             reset_n,
    output logic [1:0]       sup_state,
    output logic             wd_charging
);
    sup_state_e  st_q, st_d;
    logic        dly_done;
    logic        kick_rise;
    ramp_flags_t flags;

    rwd_kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .kick_raw(kick), .kick_rise(kick_rise)
    );

    rwd_delay #(.DLY_W(DLY_W)) u_delay (
        .clk(clk), .rst(rst), .counting(st_q == SUP_DELAY),
        .cfg_delay(cfg_delay), .done(dly_done)
    );

    rwd_ramp #(.TMO_W(TMO_W), .CHG_STEP(CHG_STEP)) u_ramp (
        .clk(clk), .rst(rst), .active(ramp_active(st_q)), .enable(wd_enable),
        .kick_rise(kick_rise), .cfg_timeout(cfg_timeout), .flags(flags)
    );

    always_comb begin
        st_d = st_q;
        if (!supply_ok) begin
            st_d = SUP_HOLD;
        end else begin
            case (st_q)
                SUP_HOLD:  st_d = SUP_DELAY;
                SUP_DELAY: if (dly_done)      st_d = SUP_RUN;
                SUP_RUN:   if (flags.expired) st_d = SUP_WDRST;
                SUP_WDRST: if (flags.at_top)  st_d = SUP_RUN;
                default:   st_d = SUP_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= SUP_HOLD;
            reset_n <= 1'b0;
        end else begin
            st_q    <= st_d;
            reset_n <= (st_d == SUP_RUN);
        end
    end

    assign sup_state   = st_q;
    assign wd_charging = flags.charging;

    // R8
    supply_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> (st_q == SUP_HOLD && !reset_n));
    // R4
    wd_fire_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == SUP_RUN && supply_ok && flags.expired) |=> (st_q == SUP_WDRST && !reset_n));
    // R2
    release_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(reset_n) |-> ($past(st_q) != SUP_HOLD));
    // R5
    pulse_end_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == SUP_WDRST && supply_ok && flags.at_top) |=> (reset_n && !wd_charging));
endmodule

// File: tb/rst_wdog_sup_tb_top.sv
`timescale 1ns/1ps
module rst_wdog_sup_tb_top;
    localparam int DLY_W = 16;
    localparam int TMO_W = 16;

    typedef struct {
        logic       rn;
        logic [1:0] st;
        int         len;
        string      tag;
    } seg_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             supply_ok = 1'b0;
    logic             kick = 1'b0;
    logic             wd_enable = 1'b1;
    logic [DLY_W-1:0] cfg_delay = 16'd20;
    logic [TMO_W-1:0] cfg_timeout = 16'd100;
    logic             reset_n;
    logic [1:0]       sup_state;
    logic             wd_charging;

    int checks = 0;
    int errors = 0;
    int tn = 0;
    int rem = 0;
    bit done = 1'b0;
    seg_t q[$];
    seg_t cur;

    always #4 clk = ~clk;

    rst_wdog_sup dut_i (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .kick(kick),
        .wd_enable(wd_enable), .cfg_delay(cfg_delay), .cfg_timeout(cfg_timeout),
        .reset_n(reset_n), .sup_state(sup_state), .wd_charging(wd_charging)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at t=%0d: actual %0d expected %0d", tag, tn, act, exp);
        end
    endtask

    task automatic push(input logic rn, input logic [1:0] st, input int len, input string tag);
        seg_t s;
        s.rn = rn; s.st = st; s.len = len; s.tag = tag;
        q.push_back(s);
    endtask

    task automatic step_to(input int t);
        while (tn < t) begin
            @(negedge clk);
            tn++;
        end
    endtask

    task automatic start_scn();
        @(negedge clk);
        tn = 0;
    endtask

    // monitor: one expected sample per cycle, 2 ns after the rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rem == 0 && q.size() > 0) begin
                cur = q.pop_front();
                rem = cur.len;
            end
            if (rem > 0) begin
                checks++;
                if (reset_n !== cur.rn || sup_state !== cur.st) begin
                    errors++;
                    $display("FAIL %s: actual reset_n=%b state=%0d expected reset_n=%b state=%0d",
                             cur.tag, reset_n, sup_state, cur.rn, cur.st);
                end
                rem--;
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset overrides a good supply
        supply_ok = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset_n", int'(reset_n), 0);
        chk("R1 state", int'(sup_state), 0);
        chk("R1 charging", int'(wd_charging), 1);
        supply_ok = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", int'(reset_n), 0);
        chk("R1 state after reset", int'(sup_state), 0);

        // Scenario A: release, free-running timeouts, supply loss, re-release
        start_scn();
        supply_ok = 1'b1;
        push(1'b0, 2'd1, 20,  "R2");
        push(1'b1, 2'd2, 111, "R4");
        push(1'b0, 2'd3, 10,  "R5");
        push(1'b1, 2'd2, 101, "R4");
        push(1'b0, 2'd3, 10,  "R5");
        push(1'b1, 2'd2, 50,  "R5");
        push(1'b0, 2'd0, 10,  "R8");
        push(1'b0, 2'd1, 20,  "R9");
        push(1'b1, 2'd2, 10,  "R9");
        push(1'b0, 2'd0, 5,   "R8");
        step_to(26);
        chk("R3 charging after release", int'(wd_charging), 1);
        step_to(41);
        chk("R3 discharging at top", int'(wd_charging), 0);
        step_to(302); supply_ok = 1'b0;
        step_to(312); supply_ok = 1'b1;
        step_to(342); supply_ok = 1'b0;
        step_to(347);

        // Scenario B: supply glitch during the delay restarts it
        start_scn();
        supply_ok = 1'b1;
        push(1'b0, 2'd1, 10, "R2");
        push(1'b0, 2'd0, 2,  "R8");
        push(1'b0, 2'd1, 20, "R9");
        push(1'b1, 2'd2, 8,  "R9");
        push(1'b0, 2'd0, 5,  "R8");
        step_to(10); supply_ok = 1'b0;
        step_to(12); supply_ok = 1'b1;
        step_to(40); supply_ok = 1'b0;
        step_to(45);

        // Scenario C: kick in charge ignored (R7), kick in discharge recharges (R6)
        start_scn();
        supply_ok = 1'b1;
        push(1'b0, 2'd1, 20,  "R2");
        push(1'b1, 2'd2, 167, "R6 R7");
        push(1'b0, 2'd3, 10,  "R5");
        push(1'b1, 2'd2, 13,  "R5");
        push(1'b0, 2'd0, 5,   "R8");
        step_to(23); kick = 1'b1;
        step_to(26); kick = 1'b0;
        step_to(79); kick = 1'b1;
        step_to(81);
        chk("R6 discharging before kick", int'(wd_charging), 0);
        step_to(82); kick = 1'b0;
        step_to(83);
        chk("R6 charging after kick", int'(wd_charging), 1);
        step_to(210); supply_ok = 1'b0;
        step_to(215);

        // Scenario D: watchdog disabled freezes ramp; supply still supervised
        start_scn();
        supply_ok = 1'b1;
        push(1'b0, 2'd1, 20,  "R2");
        push(1'b1, 2'd2, 366, "R10");
        push(1'b0, 2'd3, 10,  "R5");
        push(1'b1, 2'd2, 15,  "R10");
        push(1'b0, 2'd0, 5,   "R8");
        step_to(81); wd_enable = 1'b0;
        step_to(150);
        chk("R10 charging while disabled", int'(wd_charging), 1);
        step_to(281); wd_enable = 1'b1;
        step_to(401); wd_enable = 1'b0;
        step_to(411); supply_ok = 1'b0;
        step_to(416);
        wd_enable = 1'b1;

        repeat (3) @(negedge clk);
        chk("R2 all expectations consumed", q.size() + rem, 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule